// File: doc/BRIEF.md
# Local Interrupt Controller Mode Register

This block is the 64-bit model-specific base register of a per-core local interrupt controller. It holds a 20-bit base address, a bootstrap-processor flag that software cannot change, a global enable bit and an extended-mode bit. The enable and extended bits together place the controller in one of three states:

- `ST_OFF`: enable=0, extended=0.
- `ST_LEGACY`: enable=1, extended=0.
- `ST_EXT`: enable=1, extended=1.

Every write is checked against a table of legal state changes. A legal write commits its value on the clock edge that samples the strobe. An illegal write leaves the register untouched and produces a one-cycle fault pulse.

The named transitions are:

- `go_off`: `ST_LEGACY` or `ST_EXT` to `ST_OFF`, by writing enable=0 and extended=0.
- `go_legacy`: `ST_OFF` to `ST_LEGACY`, by writing enable=1 and extended=0.
- `go_ext`: `ST_LEGACY` to `ST_EXT`, by writing enable=1 and extended=1.
- `stay`: a write that requests the current state again.

Two transitions are forbidden: `ST_OFF` directly to `ST_EXT`, and `ST_EXT` back to `ST_LEGACY`. On `go_ext` the block computes a cluster-style logical destination from the initial controller ID. Every write, accepted or not, restores the visible controller ID to the initial ID.

The core's write-to-register path drives the write port. It turns a fault pulse into an exception. Mode, logical destination and current ID go to the rest of the interrupt controller.

Top module: `lic_mode_reg`

## Requirements
- R1: After reset the state is `ST_LEGACY` (`mode`=1; `mode` encodes 0=off, 1=legacy, 2=extended) and the base is 0xFEE00. `fault` is 0, `logical_dest` is 0 and `cur_id` equals `init_id`. The flag bit equals `bsp_strap`. `rd_data` is {32'b0, base[19:0] at bits 31:12, enable at bit 11, extended at bit 10, 0 at bit 9, flag at bit 8, 8'b0}.
- R2: A write with any bit set outside bits 31:12, 11, 10 and 8 faults and leaves `rd_data` and `mode` unchanged.
- R3: A write with bit 10 set faults when `ext_supported` is 0.
- R4: A write with bit 10 set and bit 11 clear faults.
- R5: In `ST_OFF`, a write with bits 11 and 10 both set faults and the state stays `ST_OFF`.
- R6: In `ST_EXT`, a write with bit 11 set and bit 10 clear faults and the state stays `ST_EXT`.
- R7: An accepted write takes bits 31:12 of the data as the base, and the flag at bit 8 keeps its previous value whatever the data holds.
- R8: On `go_ext`, `logical_dest` becomes ((init_id & 0xFFFF0) << 16) | (1 << (init_id & 0xF)), truncated to 32 bits, and holds that value afterwards.
- R9: An accepted write with bit 11 clear moves to `ST_OFF`. An accepted write with bit 11 set and bit 10 clear moves from `ST_OFF` to `ST_LEGACY`.
- R10: `cur_id` changes only on a write, accepted or faulted, and then takes the value of `init_id`.
- R11: `fault` is high for exactly one cycle, the cycle after a rejected write strobe. An accepted write is visible on the outputs in the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bsp_strap | input | 1 | Bootstrap-processor flag loaded at reset |
| ext_supported | input | 1 | Core supports extended mode |
| init_id | input | ID_W | Initial controller ID |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Current register value |
| mode | output | 2 | 0 off, 1 legacy, 2 extended |
| logical_dest | output | 32 | Logical destination |
| cur_id | output | ID_W | Software-visible controller ID |
| fault | output | 1 | One-cycle pulse for a rejected write |

## Verification
The assertions check four properties on every cycle:

- The two forbidden state changes never occur.
- A fault pulse always follows a strobe and coincides with an unchanged register.
- The bootstrap flag never moves after reset.
- The destination matches the formula at the moment extended mode is entered.

Other behaviours can only be shown by the bench's scenarios: which writes are rejected for which reason, the base value taken from an accepted write, the return from off to legacy, and the restoring of the ID on faulted writes.

// File: rtl/lic_pkg.sv
package lic_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_LEGACY = 2'd1,
        ST_EXT    = 2'd2
    } lic_state_t;

    localparam int REG_W    = 64;
    localparam int BASE_W   = 20;
    localparam int DEST_W   = 32;
    localparam int BIT_BSP  = 8;
    localparam int BIT_EXT  = 10;
    localparam int BIT_EN   = 11;
    localparam int BASE_LO  = 12;
    localparam int BASE_HI  = BASE_LO + BASE_W - 1;
    localparam logic [REG_W-1:0] WRITABLE_MASK = 64'h0000_0000_FFFF_FD00;
endpackage

// File: rtl/lic_wr_check.sv
module lic_wr_check
    import lic_pkg::*;
(
    input  lic_state_t         cur,
    input  logic [REG_W-1:0]   wdata,
    input  logic               ext_ok,
    output logic               reject,
    output lic_state_t         nxt
);
    logic want_en;
    logic want_ext;
    logic rsv_hit;
    logic bad;

    always_comb begin
        want_en  = wdata[BIT_EN];
        want_ext = wdata[BIT_EXT];
        rsv_hit  = |(wdata & ~WRITABLE_MASK);
        bad      = rsv_hit | (want_ext & ~ext_ok) | (want_ext & ~want_en);
        nxt      = cur;
        unique case (cur)
            ST_OFF: begin
                if (want_en && want_ext) bad = 1'b1;
                else if (want_en)        nxt = ST_LEGACY;
            end
            ST_LEGACY: begin
                if (!want_en)      nxt = ST_OFF;
                else if (want_ext) nxt = ST_EXT;
            end
            ST_EXT: begin
                if (!want_en)       nxt = ST_OFF;
                else if (!want_ext) bad = 1'b1;
            end
            default: nxt = ST_OFF;
        endcase
        if (bad) nxt = cur;
        reject = bad;
    end
endmodule

// File: rtl/lic_dest_calc.sv
module lic_dest_calc
    import lic_pkg::*;
(
    input  logic [15:0]       low_id,
    output logic [DEST_W-1:0] dest
);
    always_comb begin
        dest = {low_id[15:4], {(DEST_W-12){1'b0}}} | (DEST_W'(1) << low_id[3:0]);
    end
endmodule

// File: rtl/lic_mode_reg.sv
module lic_mode_reg
    import lic_pkg::*;
#(
    parameter int               ID_W       = 32,
    parameter logic [BASE_W-1:0] RESET_BASE = 20'hFEE00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bsp_strap,
    input  logic               ext_supported,
    input  logic [ID_W-1:0]    init_id,
    input  logic               wr_valid,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic [1:0]         mode,
    output logic [DEST_W-1:0]  logical_dest,
    output logic [ID_W-1:0]    cur_id,
    output logic               fault
);
    lic_state_t        state_q;
    lic_state_t        state_d;
    logic              reject;
    logic [BASE_W-1:0] base_q;
    logic              bsp_q;
    logic [DEST_W-1:0] dest_q;
    logic [DEST_W-1:0] dest_new;
    logic [ID_W-1:0]   id_q;
    logic              fault_q;
    logic              take;

    lic_wr_check u_check (
        .cur    (state_q),
        .wdata  (wr_data),
        .ext_ok (ext_supported),
        .reject (reject),
        .nxt    (state_d)
    );

    lic_dest_calc u_dest (
        .low_id (init_id[15:0]),
        .dest   (dest_new)
    );

    assign take = wr_valid & ~reject;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LEGACY;
        else if (take) state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= RESET_BASE;
            bsp_q   <= bsp_strap;
            dest_q  <= '0;
            id_q    <= init_id;
            fault_q <= 1'b0;
        end else begin
            fault_q <= wr_valid & reject;
            if (wr_valid) id_q <= init_id;
            if (take) begin
                base_q <= wr_data[BASE_HI:BASE_LO];
                if (state_q == ST_LEGACY && state_d == ST_EXT) dest_q <= dest_new;
            end
        end
    end

    // outputs
    always_comb begin
        rd_data                   = '0;
        rd_data[BASE_HI:BASE_LO]  = base_q;
        rd_data[BIT_EN]           = (state_q != ST_OFF);
        rd_data[BIT_EXT]          = (state_q == ST_EXT);
        rd_data[BIT_BSP]          = bsp_q;
        mode                      = state_q;
        logical_dest              = dest_q;
        cur_id                    = id_q;
        fault                     = fault_q;
    end

    assert_no_off_to_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> (mode != 2'd2));

    assert_no_ext_to_legacy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |=> (mode != 2'd1));

    assert_fault_keeps_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(rd_data) && $stable(mode)));

    assert_fault_after_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(wr_valid));

    assert_bsp_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(rd_data[BIT_BSP]));

    assert_ext_entry_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(mode == 2'd2)) |->
        (logical_dest == ({$past(init_id[15:4]), 20'b0} | (32'd1 << $past(init_id[3:0])))));
endmodule

// File: tb/lic_mode_reg_bench.sv
module lic_mode_reg_bench;
    import lic_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bsp_strap = 1'b1;
    logic              ext_supported = 1'b0;
    logic [31:0]       init_id = 32'h0001_2345;
    logic              wr_valid = 1'b0;
    logic [63:0]       wr_data = '0;
    logic [63:0]       rd_data;
    logic [1:0]        mode;
    logic [31:0]       logical_dest;
    logic [31:0]       cur_id;
    logic              fault;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lic_mode_reg u_lic_mode_reg (
        .clk           (clk),
        .rst_n         (rst_n),
        .bsp_strap     (bsp_strap),
        .ext_supported (ext_supported),
        .init_id       (init_id),
        .wr_valid      (wr_valid),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .mode          (mode),
        .logical_dest  (logical_dest),
        .cur_id        (cur_id),
        .fault         (fault)
    );

    // {wdata, ext_supported, fault, mode, rd_data[31:0]}
    localparam int NV = 12;
    localparam logic [99:0] VEC [NV] = '{
        {64'h0000_0001_FEE0_0800, 1'b1, 1'b1, 2'd1, 32'hFEE0_0900}, // R2 bit 32
        {64'h0000_0000_FEE0_0A00, 1'b1, 1'b1, 2'd1, 32'hFEE0_0900}, // R2 bit 9
        {64'h0000_0000_FEE0_0C00, 1'b0, 1'b1, 2'd1, 32'hFEE0_0900}, // R3
        {64'h0000_0000_FEE0_0400, 1'b1, 1'b1, 2'd1, 32'hFEE0_0900}, // R4
        {64'h0000_0000_1234_5800, 1'b1, 1'b0, 2'd1, 32'h1234_5900}, // R7
        {64'h0000_0000_1234_5000, 1'b1, 1'b0, 2'd0, 32'h1234_5100}, // R9 off
        {64'h0000_0000_1234_5C00, 1'b1, 1'b1, 2'd0, 32'h1234_5100}, // R5
        {64'h0000_0000_ABCD_E800, 1'b1, 1'b0, 2'd1, 32'hABCD_E900}, // R9 legacy
        {64'h0000_0000_ABCD_EC00, 1'b1, 1'b0, 2'd2, 32'hABCD_ED00}, // R8
        {64'h0000_0000_ABCD_E800, 1'b1, 1'b1, 2'd2, 32'hABCD_ED00}, // R6
        {64'h0000_0000_ABCD_EC00, 1'b1, 1'b0, 2'd2, 32'hABCD_ED00}, // stay
        {64'h0000_0000_0000_0000, 1'b1, 1'b0, 2'd0, 32'h0000_0100}  // R9 ext off
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [63:0] d, input logic sup);
        @(negedge clk);
        wr_valid      = 1'b1;
        wr_data       = d;
        ext_supported = sup;
        @(negedge clk);
        wr_valid      = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode", {62'b0, mode}, 64'd1);
        chk("R1 rd_data", rd_data, 64'h0000_0000_FEE0_0900);
        chk("R1 fault", {63'b0, fault}, 64'd0);
        chk("R1 dest", {32'b0, logical_dest}, 64'd0);
        chk("R1 cur_id", {32'b0, cur_id}, 64'h0001_2345);

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][99:36], VEC[i][35]);
            chk($sformatf("vec%0d fault R11", i), {63'b0, fault}, {63'b0, VEC[i][34]});
            chk($sformatf("vec%0d mode R9", i), {62'b0, mode}, {62'b0, VEC[i][33:32]});
            chk($sformatf("vec%0d rd_data R7", i), rd_data, {32'b0, VEC[i][31:0]});
            if (i == 8) chk("R8 dest", {32'b0, logical_dest}, 64'h2340_0020);
        end

        // R8 dest holds after leaving extended mode
        chk("R8 dest held", {32'b0, logical_dest}, 64'h2340_0020);

        // R10: ID only follows init_id on a write, also a faulted one
        init_id = 32'h0000_0077;
        repeat (3) @(negedge clk);
        chk("R10 id idle", {32'b0, cur_id}, 64'h0001_2345);
        do_write(64'h0000_0000_0000_0001, 1'b1);
        chk("R10 id after fault write", {32'b0, cur_id}, 64'h0000_0077);
        chk("R2 reserved bit0 fault", {63'b0, fault}, 64'd1);
        @(negedge clk);
        chk("R11 fault one cycle", {63'b0, fault}, 64'd0);
        chk("R2 register unchanged", rd_data, 64'h0000_0000_0000_0100);

        // R8 with another ID via off -> legacy -> extended
        init_id = 32'h000A_BCDF;
        do_write(64'h0000_0000_0000_0800, 1'b1);
        do_write(64'h0000_0000_0000_0C00, 1'b1);
        chk("R8 mode ext", {62'b0, mode}, 64'd2);
        chk("R8 dest second", {32'b0, logical_dest}, 64'hBCD0_8000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule